// File: doc/BRIEF.md
# ADC Code Error Monitor

This block observes the parallel output codes of a fast converter while a beat-frequency sine is applied during a radiation test. A well-behaved input changes by less than one LSB from one sample to the next. A larger jump between consecutive codes is therefore taken as a transient-induced code error. Errors are counted as whole-code upset events, never as flipped bits.

The converter's output is demultiplexed 1:2. On each output clock the block receives one earlier sample on a delayed lane and one later sample on a direct lane. The block puts these two samples back in time order and compares each sample with the one before it, including across clock edges. Over-threshold samples are grouped into events; clean runs up to a programmable length are bridged within an event. The block accumulates an event count and a count of error samples that stands for outage time. It also keeps a snapshot of the first error.

Software reads the results through a small combinational register port.

Top module: `code_err_mon`

## Requirements
- R1: The sample on `lane_dly` is the earlier sample and the sample on `lane_dir` is the later one. The earlier sample is compared with the previous pair's `lane_dir` sample, and the later sample is compared with the earlier one.
- R2: A sample is an error when the absolute difference to its predecessor is strictly greater than `threshold`. A difference equal to `threshold` is not an error.
- R3: The first sample accepted after `enable` rises, after reset or after `clear` serves only as a reference and is never an error.
- R4: An error sample that is not inside an event starts a new event and raises the event count by one. After an error sample, up to `gap_len` clean samples keep the event open. The next clean sample after that ends the event.
- R5: The outage count rises by one for every error sample.
- R6: Both counters are CNT_W bits wide and saturate at their all-ones value instead of wrapping.
- R7: The first error after reset or `clear` latches its sample index (counted from 0 since the last clear), its predecessor code and its own code. The capture holds until `clear`. When both samples of a pair are errors, the earlier one is captured.
- R8: A one-cycle `clear` zeroes both counters, the capture and the sample index, and drops the reference sample.
- R9: A pair presented at one rising edge is reflected in the registers after the second rising edge. Read map on `rd_addr`: 0 event count, 1 outage count, 2 capture-valid in bit 0, 3 captured index, 4 predecessor code in bits 15:8 and error code in bits 7:0.
- R10: While `enable` is low, presented pairs change no counter, capture or index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Monitoring enable |
| clear | input | 1 | Synchronous clear of results and reference |
| pair_vld | input | 1 | A sample pair is present on the lanes |
| lane_dly | input | 8 | Earlier sample of the pair |
| lane_dir | input | 8 | Later sample of the pair |
| threshold | input | 8 | Largest tolerated code step in LSB (typically 6) |
| gap_len | input | 8 | Clean samples bridged inside one event |
| rd_addr | input | 3 | Register select |
| rd_data | output | 32 | Selected register value |

## Verification
The hardest situations to reach are those whose outcome depends on sample order across the pair boundary. The stimulus therefore places jumps so that swapped lanes, or a lost previous direct sample, would change the outage total. An example is a downward step on the direct lane that is clean only if the delayed sample is compared first. A table of pairs with gap set to one exercises merging, ending and restarting of events and the equal-to-threshold boundary. A directed run of alternating levels with the gap set to zero produces more events than a narrowed counter can hold, so that saturation is reached in a short run.

// File: rtl/cem_pkg.sv
// Shared definitions for the code error monitor.
// Assumes codes are unsigned and every sample in a pair uses the same width.
package cem_pkg;
    localparam int CODE_W  = 8;
    localparam int LANES   = 2;
    localparam int RD_W    = 32;

    // One reordered sample with its predecessor and error verdict.
    typedef struct packed {
        logic              err;
        logic [CODE_W-1:0] prev;
        logic [CODE_W-1:0] code;
    } samp_t;

    // Read map addresses.
    localparam logic [2:0] A_EVENTS = 3'd0;
    localparam logic [2:0] A_OUTAGE = 3'd1;
    localparam logic [2:0] A_STATUS = 3'd2;
    localparam logic [2:0] A_INDEX  = 3'd3;
    localparam logic [2:0] A_CODES  = 3'd4;
endpackage

// File: rtl/cem_order.sv
// Restores time order of a 1:2 demultiplexed pair and flags code steps
// above threshold. Assumes lane_dly holds the earlier sample.
// One register stage: the verdicts appear one edge after the pair.
module cem_order
    import cem_pkg::*;
#(
    parameter int IDX_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  clear,
    input  logic                  pair_vld,
    input  logic [CODE_W-1:0]     lane_dly,
    input  logic [CODE_W-1:0]     lane_dir,
    input  logic [CODE_W-1:0]     threshold,
    output logic                  stg_vld,
    output samp_t [LANES-1:0]     stg_samp,
    output logic [IDX_W-1:0]      stg_idx
);
    localparam logic [IDX_W-1:0] STEP = IDX_W'(LANES);

    logic [CODE_W-1:0] prev_q;
    logic              have_ref;
    logic [IDX_W-1:0]  idx_q;
    logic              take;
    samp_t [LANES-1:0] cur;

    function automatic logic [CODE_W-1:0] absdiff(input logic [CODE_W-1:0] a,
                                                  input logic [CODE_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    assign take = pair_vld && enable && !clear;

    // Build the time-ordered samples and their verdicts.
    always_comb begin
        cur[0].code = lane_dly;
        cur[0].prev = prev_q;
        cur[1].code = lane_dir;
        cur[1].prev = lane_dly;
        for (int i = 0; i < LANES; i++) begin
            cur[i].err = (absdiff(cur[i].code, cur[i].prev) > threshold)
                         && ((i != 0) || have_ref);
        end
    end

    // Register the verdicts, the reference sample and the running index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_vld  <= 1'b0;
            stg_samp <= '0;
            stg_idx  <= '0;
            prev_q   <= '0;
            have_ref <= 1'b0;
            idx_q    <= '0;
        end else if (clear) begin
            stg_vld  <= 1'b0;
            have_ref <= 1'b0;
            idx_q    <= '0;
        end else begin
            stg_vld <= take;
            if (take) begin
                stg_samp <= cur;
                stg_idx  <= idx_q;
                idx_q    <= idx_q + STEP;
                prev_q   <= lane_dir;
                have_ref <= 1'b1;
            end else if (!enable) begin
                have_ref <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cem_events.sv
// Groups error samples into events and keeps saturating totals.
// Assumes samples within a stage entry are in time order (index 0 first).
module cem_events
    import cem_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int GAP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              stg_vld,
    input  logic [LANES-1:0]  stg_err,
    input  logic [GAP_W-1:0]  gap_len,
    output logic [CNT_W-1:0]  ev_cnt,
    output logic [CNT_W-1:0]  out_cnt
);
    localparam int INC_W = $clog2(LANES + 1);

    logic             in_ev_q, in_ev_n;
    logic [GAP_W-1:0] gap_q, gap_n;
    logic [INC_W-1:0] ev_inc, out_inc;

    function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                 input logic [INC_W-1:0] b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + (CNT_W+1)'(b);
        return s[CNT_W] ? '1 : s[CNT_W-1:0];
    endfunction

    // Walk the samples of one entry in order and update the event state.
    always_comb begin
        in_ev_n = in_ev_q;
        gap_n   = gap_q;
        ev_inc  = '0;
        out_inc = '0;
        if (stg_vld) begin
            for (int i = 0; i < LANES; i++) begin
                if (stg_err[i]) begin
                    if (!in_ev_n) ev_inc = ev_inc + 1'b1;
                    in_ev_n = 1'b1;
                    gap_n   = '0;
                    out_inc = out_inc + 1'b1;
                end else if (in_ev_n) begin
                    if (gap_n >= gap_len) in_ev_n = 1'b0;
                    else                  gap_n   = gap_n + 1'b1;
                end
            end
        end
    end

    // Hold the event state and the saturating totals.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            in_ev_q <= 1'b0;
            gap_q   <= '0;
            ev_cnt  <= '0;
            out_cnt <= '0;
        end else begin
            in_ev_q <= in_ev_n;
            gap_q   <= gap_n;
            ev_cnt  <= sat_add(ev_cnt, ev_inc);
            out_cnt <= sat_add(out_cnt, out_inc);
        end
    end
endmodule

// File: rtl/cem_capture.sv
// Latches the first error sample (index, predecessor, code) until clear.
// Assumes index 0 of the stage entry is the earlier sample.
module cem_capture
    import cem_pkg::*;
#(
    parameter int IDX_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  stg_vld,
    input  samp_t [LANES-1:0]     stg_samp,
    input  logic [IDX_W-1:0]      stg_idx,
    output logic                  cap_vld,
    output logic [IDX_W-1:0]      cap_idx,
    output logic [CODE_W-1:0]     cap_prev,
    output logic [CODE_W-1:0]     cap_code
);
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    samp_t            hit_samp;

    // Pick the earliest error sample of the entry.
    always_comb begin
        hit      = 1'b0;
        hit_idx  = stg_idx;
        hit_samp = stg_samp[0];
        for (int i = LANES - 1; i >= 0; i--) begin
            if (stg_samp[i].err) begin
                hit      = 1'b1;
                hit_idx  = stg_idx + IDX_W'(i);
                hit_samp = stg_samp[i];
            end
        end
    end

    // Store the first error and keep it until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cap_vld  <= 1'b0;
            cap_idx  <= '0;
            cap_prev <= '0;
            cap_code <= '0;
        end else if (stg_vld && hit && !cap_vld) begin
            cap_vld  <= 1'b1;
            cap_idx  <= hit_idx;
            cap_prev <= hit_samp.prev;
            cap_code <= hit_samp.code;
        end
    end
endmodule

// File: rtl/code_err_mon.sv
// Code error monitor top: reorder/compare stage, event grouping, first-error
// capture and a combinational register read port.
// Assumes CNT_W and IDX_W do not exceed the 32-bit read width.
module code_err_mon
    import cem_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int IDX_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              clear,
    input  logic              pair_vld,
    input  logic [7:0]        lane_dly,
    input  logic [7:0]        lane_dir,
    input  logic [7:0]        threshold,
    input  logic [7:0]        gap_len,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data
);
    logic                  stg_vld;
    samp_t [LANES-1:0]     stg_samp;
    logic [IDX_W-1:0]      stg_idx;
    logic [LANES-1:0]      stg_err;
    logic [CNT_W-1:0]      ev_cnt, out_cnt;
    logic                  cap_vld;
    logic [IDX_W-1:0]      cap_idx;
    logic [CODE_W-1:0]     cap_prev, cap_code;

    cem_order #(.IDX_W(IDX_W)) u_order (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
        .pair_vld(pair_vld), .lane_dly(lane_dly), .lane_dir(lane_dir),
        .threshold(threshold), .stg_vld(stg_vld), .stg_samp(stg_samp),
        .stg_idx(stg_idx)
    );

    // Gather the per-sample verdicts for the event stage.
    for (genvar g = 0; g < LANES; g++) begin : g_err
        assign stg_err[g] = stg_samp[g].err;
    end

    cem_events #(.CNT_W(CNT_W), .GAP_W(8)) u_events (
        .clk(clk), .rst_n(rst_n), .clear(clear), .stg_vld(stg_vld),
        .stg_err(stg_err), .gap_len(gap_len), .ev_cnt(ev_cnt),
        .out_cnt(out_cnt)
    );

    cem_capture #(.IDX_W(IDX_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .clear(clear), .stg_vld(stg_vld),
        .stg_samp(stg_samp), .stg_idx(stg_idx), .cap_vld(cap_vld),
        .cap_idx(cap_idx), .cap_prev(cap_prev), .cap_code(cap_code)
    );

    // Select the register named by rd_addr.
    always_comb begin
        unique case (rd_addr)
            A_EVENTS: rd_data = RD_W'(ev_cnt);
            A_OUTAGE: rd_data = RD_W'(out_cnt);
            A_STATUS: rd_data = RD_W'(cap_vld);
            A_INDEX:  rd_data = RD_W'(cap_idx);
            A_CODES:  rd_data = RD_W'({cap_prev, cap_code});
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cem_checker.sv
// Temporal checks on the code error monitor, bound to its top.
module cem_checker #(
    parameter int CNT_W = 32,
    parameter int IDX_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic [CNT_W-1:0] ev_cnt,
    input logic [CNT_W-1:0] out_cnt,
    input logic             cap_vld,
    input logic [IDX_W-1:0] cap_idx,
    input logic [7:0]       cap_code
);
    // R4: at most one new event per clock.
    a_r4_one_event_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (ev_cnt - $past(ev_cnt)) <= CNT_W'(1));

    // R4/R5: every event contains at least one error sample.
    a_r4_events_le_outage: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cnt <= out_cnt);

    // R5: at most two error samples per clock.
    a_r5_outage_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (out_cnt - $past(out_cnt)) <= CNT_W'(2));

    // R6: counters never wrap downward without clear.
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (ev_cnt >= $past(ev_cnt)) && (out_cnt >= $past(out_cnt)));

    // R7: capture is held until clear.
    a_r7_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vld && !clear) |=> cap_vld && $stable(cap_idx) && $stable(cap_code));

    // R8: clear empties the results.
    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ev_cnt == '0) && (out_cnt == '0) && !cap_vld);
endmodule

bind code_err_mon cem_checker #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .ev_cnt(ev_cnt),
    .out_cnt(out_cnt), .cap_vld(cap_vld), .cap_idx(cap_idx),
    .cap_code(cap_code)
);

// File: tb/code_err_mon_tb.sv
module code_err_mon_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TB_CNT_W   = 5;
    localparam int NVEC       = 8;
    // {lane_dly, lane_dir, expected events, expected outage} after each pair
    // (threshold 6, gap 1).
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd100, 8'd101, 8'd0, 8'd0},
        {8'd102, 8'd102, 8'd0, 8'd0},
        {8'd120, 8'd121, 8'd1, 8'd1},
        {8'd122, 8'd140, 8'd2, 8'd2},
        {8'd141, 8'd100, 8'd2, 8'd3},
        {8'd106, 8'd112, 8'd2, 8'd3},
        {8'd113, 8'd105, 8'd3, 8'd4},
        {8'd104, 8'd104, 8'd3, 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        clear = 1'b0;
    logic        pair_vld = 1'b0;
    logic [7:0]  lane_dly = '0;
    logic [7:0]  lane_dir = '0;
    logic [7:0]  threshold = 8'd6;
    logic [7:0]  gap_len = 8'd1;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    code_err_mon #(.CNT_W(TB_CNT_W), .IDX_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
        .pair_vld(pair_vld), .lane_dly(lane_dly), .lane_dir(lane_dir),
        .threshold(threshold), .gap_len(gap_len), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s addr %0d actual %0d expected %0d", req, a, rd_data, exp);
        end
    endtask

    // Present one pair, then wait until it is reflected (two edges).
    task automatic send(input logic [7:0] d, input logic [7:0] e);
        @(negedge clk);
        lane_dly = d; lane_dir = e; pair_vld = 1'b1;
        @(negedge clk);
        pair_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state through the read map
        rd_chk("R9 reset events", 3'd0, 32'd0);
        rd_chk("R9 reset outage", 3'd1, 32'd0);
        rd_chk("R9 reset status", 3'd2, 32'd0);

        enable = 1'b1;
        // R1 R2 R3 R4 R5: table walk
        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i][31:24], VEC[i][23:16]);
            rd_chk("R4 table events", 3'd0, 32'(VEC[i][15:8]));
            rd_chk("R5 R1 R2 table outage", 3'd1, 32'(VEC[i][7:0]));
        end
        // R7 first error: index 4, prev 102, code 120
        rd_chk("R7 capture valid", 3'd2, 32'd1);
        rd_chk("R7 capture index", 3'd3, 32'd4);
        rd_chk("R7 capture codes", 3'd4, {16'd0, 8'd102, 8'd120});

        // R10: disabled pairs ignored
        enable = 1'b0;
        send(8'd0, 8'd200);
        rd_chk("R10 disabled events", 3'd0, 32'd3);
        rd_chk("R10 disabled outage", 3'd1, 32'd4);
        // R3: first sample after enable is reference
        enable = 1'b1;
        send(8'd0, 8'd0);
        rd_chk("R3 reference events", 3'd0, 32'd3);
        rd_chk("R3 reference outage", 3'd1, 32'd4);
        send(8'd30, 8'd30);
        rd_chk("R3 after reference events", 3'd0, 32'd4);
        rd_chk("R7 capture held", 3'd3, 32'd4);

        // R8 clear
        pulse_clear();
        rd_chk("R8 clear events", 3'd0, 32'd0);
        rd_chk("R8 clear outage", 3'd1, 32'd0);
        rd_chk("R8 clear status", 3'd2, 32'd0);

        // R6 saturation with gap 0: one event per pair after the reference
        gap_len = 8'd0;
        send(8'd50, 8'd50);
        rd_chk("R8 reference after clear", 3'd1, 32'd0);
        for (int k = 0; k < 40; k++) begin
            if (k % 2 == 0) send(8'd0, 8'd0);
            else            send(8'd50, 8'd50);
        end
        rd_chk("R6 events saturate", 3'd0, 32'd31);
        rd_chk("R6 outage saturates", 3'd1, 32'd31);
        rd_chk("R7 R8 index restarts", 3'd3, 32'd2);
        rd_chk("R7 capture after clear", 3'd4, {16'd0, 8'd50, 8'd0});

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule